// File: doc/BRIEF.md
# Retiming Lookup-Table Logic Block

A configurable logic cell for a fine-grained fabric. Its core is a four-input lookup table, and each table input carries its own register chain with a programmable tap. A signal can therefore be delayed by up to `CHAIN_DEPTH` cycles where it enters the cell, without spending interconnect on separate flip-flops. The table result leaves the cell either straight through or through an optional output register.

A second operating mode bypasses the table. The four input chains are joined in pairs to form two independent delay lines, each with its own output. The cell then serves as pure retiming storage with up to `2*CHAIN_DEPTH` cycles of delay per lane.

Configuration is loaded over a parallel write port. A write is accepted only while the cell is held idle by a configuration-enable input. While that input is high, the outputs read zero and all pipeline state is cleared.

Top module: `rlb_block`

## Requirements
- R1: A synchronous active-high `rst` clears the configuration to all-zero (truth table 0, every delay 0, no output register, table mode), all chain registers and the output registers. With that configuration, `blk_out` reads 0 and `cfg_nack` reads 0.
- R2: In table mode, `blk_out[0]` equals bit `{in3,in2,in1,in0}` of the 16-bit truth table, where input 0 is the least significant index bit. With every delay at 0 and the output register off, this holds combinationally in the same cycle.
- R3: The 3-bit delay select of input i sits at `cfg_delay[3i+2:3i]`. A value k in the range 0..`CHAIN_DEPTH` makes the table see that input as it was k cycles earlier, independently of the other inputs. Values from before the last clear read as 0.
- R4: When `cfg_oreg` is written as 1, each lane output is delayed by one extra cycle through a register. In the first cycle after a clear, that register reads 0.
- R5: When `cfg_dual` is written as 1, `blk_out[0]` is input 0 delayed by the sum of selects 0 and 1, and `blk_out[1]` is input 2 delayed by the sum of selects 2 and 3. Each lane reaches at most 2·`CHAIN_DEPTH` cycles. Inputs 1 and 3 are not used in this mode.
- R6: In table mode, `blk_out[1]` is always 0.
- R7: A write that carries any delay select above `CHAIN_DEPTH` (5, 6 or 7) is rejected as a whole and leaves the previous configuration in force. `cfg_nack` is 1 in the cycle after such a write and 0 after an accepted write.
- R8: `cfg_we` has no effect while `cfg_en` is low: the configuration does not change, and `cfg_nack` stays 0.
- R9: While `cfg_en` is high, `blk_out` is 0 and every chain and output register is cleared. Operation after `cfg_en` falls therefore starts from all-zero history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for every register |
| rst | input | 1 | Synchronous active-high reset |
| din | input | LUT_K | Cell inputs; bit i feeds chain i |
| cfg_en | input | 1 | Holds the cell idle and opens the configuration port |
| cfg_we | input | 1 | Write strobe for the configuration fields |
| cfg_truth | input | 2**LUT_K | Truth table, index = input vector |
| cfg_delay | input | LUT_K*SEL_W | Per-input delay selects, input i at bits [SEL_W*i +: SEL_W] |
| cfg_oreg | input | 1 | 1 = take outputs through the output register |
| cfg_dual | input | 1 | 1 = dual delay-line mode, 0 = table mode |
| blk_out | output | LUT_K/2 | Lane outputs; lane 0 carries the table result in table mode |
| cfg_nack | output | 1 | One-cycle flag marking a rejected configuration write |

## Verification
Every one of the 625 combinations of the four delay selects is exercised in both modes and with the output register on and off. Each combination is fed a pseudo-random input stream and paired with a fresh random truth table. An error that swaps chains, taps the wrong stage, or adds the paired selects incorrectly shows up as a mismatch against the history kept in the bench.

Two further sets of directed tests complete the coverage. A full sweep of all 16 input vectors against single-hot and mixed truth tables separates index-bit ordering faults from delay faults. Out-of-range selects in each slot, writes made with the enable low, and an idle window with the inputs toggling check the rejection, write-gating and clearing rules.

// File: rtl/rlb_pkg.sv
`timescale 1ns/1ps
package rlb_pkg;
  typedef enum logic {
    MODE_TABLE = 1'b0,
    MODE_DUAL  = 1'b1
  } rlb_mode_e;
endpackage

// File: rtl/rlb_delay_tap.sv
`timescale 1ns/1ps
// One input chain: CHAIN_DEPTH shift stages and a tap selector (0 = bypass).
module rlb_delay_tap #(
  parameter int CHAIN_DEPTH = 4,
  parameter int SEL_W       = 3
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             d,
  input  logic [SEL_W-1:0] sel,
  output logic             q
);
  logic [CHAIN_DEPTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (clr) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < CHAIN_DEPTH; k++) begin
        stg[k] <= stg[k-1];
      end
    end
  end

  always_comb begin
    q = d;
    for (int k = 1; k <= CHAIN_DEPTH; k++) begin
      if (sel == SEL_W'(k)) q = stg[k-1];
    end
  end
endmodule

// File: rtl/rlb_lut.sv
`timescale 1ns/1ps
module rlb_lut #(
  parameter int LUT_K = 4,
  parameter int TT_W  = 16
) (
  input  logic [TT_W-1:0]  truth,
  input  logic [LUT_K-1:0] idx,
  output logic             f
);
  assign f = truth[idx];
endmodule

// File: rtl/rlb_cfg_store.sv
`timescale 1ns/1ps
module rlb_cfg_store #(
  parameter int LUT_K       = 4,
  parameter int CHAIN_DEPTH = 4,
  parameter int SEL_W       = 3,
  parameter int TT_W        = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_en,
  input  logic                   cfg_we,
  input  logic [TT_W-1:0]        wr_truth,
  input  logic [LUT_K*SEL_W-1:0] wr_sel,
  input  logic                   wr_oreg,
  input  rlb_pkg::rlb_mode_e     wr_mode,
  output logic [TT_W-1:0]        act_truth,
  output logic [LUT_K*SEL_W-1:0] act_sel,
  output logic                   act_oreg,
  output rlb_pkg::rlb_mode_e     act_mode,
  output logic                   wr_nack
);
  logic [LUT_K-1:0] over;
  logic             wr_try;
  logic             wr_ok;

  for (genvar i = 0; i < LUT_K; i++) begin : g_range
    assign over[i] = ({1'b0, wr_sel[i*SEL_W +: SEL_W]} > (SEL_W+1)'(CHAIN_DEPTH));
  end

  assign wr_try = cfg_en & cfg_we;
  assign wr_ok  = wr_try & ~(|over);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_truth <= '0;
      act_sel   <= '0;
      act_oreg  <= 1'b0;
      act_mode  <= rlb_pkg::MODE_TABLE;
      wr_nack   <= 1'b0;
    end else begin
      if (wr_ok) begin
        act_truth <= wr_truth;
        act_sel   <= wr_sel;
        act_oreg  <= wr_oreg;
        act_mode  <= wr_mode;
      end
      wr_nack <= wr_try & (|over);
    end
  end
endmodule

// File: rtl/rlb_block.sv
`timescale 1ns/1ps
module rlb_block #(
  parameter int LUT_K       = 4,
  parameter int CHAIN_DEPTH = 4,
  localparam int SEL_W      = $clog2(CHAIN_DEPTH + 1),
  localparam int TT_W       = 1 << LUT_K,
  localparam int N_LANE     = LUT_K / 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LUT_K-1:0]       din,
  input  logic                   cfg_en,
  input  logic                   cfg_we,
  input  logic [TT_W-1:0]        cfg_truth,
  input  logic [LUT_K*SEL_W-1:0] cfg_delay,
  input  logic                   cfg_oreg,
  input  logic                   cfg_dual,
  output logic [N_LANE-1:0]      blk_out,
  output logic                   cfg_nack
);
  import rlb_pkg::*;

  logic [TT_W-1:0]        act_truth;
  logic [LUT_K*SEL_W-1:0] act_sel;
  logic                   act_oreg;
  rlb_mode_e              act_mode;
  logic                   act_dual;
  rlb_mode_e              wr_mode;
  logic                   chain_clr;
  logic [LUT_K-1:0]       tap_in;
  logic [LUT_K-1:0]       tap_q;
  logic                   lut_f;
  logic [N_LANE-1:0]      lane_pre;
  logic [N_LANE-1:0]      lane_q;

  assign wr_mode   = cfg_dual ? MODE_DUAL : MODE_TABLE;
  assign act_dual  = (act_mode == MODE_DUAL);
  assign chain_clr = rst | cfg_en;

  rlb_cfg_store #(
    .LUT_K(LUT_K), .CHAIN_DEPTH(CHAIN_DEPTH), .SEL_W(SEL_W), .TT_W(TT_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_we(cfg_we),
    .wr_truth(cfg_truth), .wr_sel(cfg_delay), .wr_oreg(cfg_oreg), .wr_mode(wr_mode),
    .act_truth(act_truth), .act_sel(act_sel), .act_oreg(act_oreg), .act_mode(act_mode),
    .wr_nack(cfg_nack)
  );

  // Odd chains follow their even neighbour in dual mode.
  for (genvar i = 0; i < LUT_K; i++) begin : g_chain
    if (i % 2 == 1) begin : g_odd
      assign tap_in[i] = act_dual ? tap_q[i-1] : din[i];
    end else begin : g_even
      assign tap_in[i] = din[i];
    end
    rlb_delay_tap #(.CHAIN_DEPTH(CHAIN_DEPTH), .SEL_W(SEL_W)) u_tap (
      .clk(clk), .clr(chain_clr), .d(tap_in[i]),
      .sel(act_sel[i*SEL_W +: SEL_W]), .q(tap_q[i])
    );
  end

  rlb_lut #(.LUT_K(LUT_K), .TT_W(TT_W)) u_lut (
    .truth(act_truth), .idx(tap_q), .f(lut_f)
  );

  for (genvar j = 0; j < N_LANE; j++) begin : g_lane
    if (j == 0) begin : g_first
      assign lane_pre[j] = act_dual ? tap_q[2*j+1] : lut_f;
    end else begin : g_rest
      assign lane_pre[j] = act_dual ? tap_q[2*j+1] : 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (chain_clr) lane_q <= '0;
    else           lane_q <= lane_pre;
  end

  assign blk_out = cfg_en ? '0 : (act_oreg ? lane_q : lane_pre);
endmodule

// File: rtl/rlb_block_chk.sv
`timescale 1ns/1ps
module rlb_block_chk #(
  parameter int LUT_K       = 4,
  parameter int CHAIN_DEPTH = 4,
  localparam int SEL_W      = $clog2(CHAIN_DEPTH + 1),
  localparam int TT_W       = 1 << LUT_K,
  localparam int N_LANE     = LUT_K / 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic [LUT_K-1:0]       din,
  input logic                   cfg_en,
  input logic                   cfg_we,
  input logic [LUT_K*SEL_W-1:0] cfg_delay,
  input logic [N_LANE-1:0]      blk_out,
  input logic                   cfg_nack,
  input logic [TT_W-1:0]        act_truth,
  input logic [LUT_K*SEL_W-1:0] act_sel,
  input logic                   act_oreg,
  input logic                   act_dual
);
  logic bad_sel;
  always_comb begin
    bad_sel = 1'b0;
    for (int i = 0; i < LUT_K; i++) begin
      if (int'(cfg_delay[i*SEL_W +: SEL_W]) > CHAIN_DEPTH) bad_sel = 1'b1;
    end
  end

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_en |-> blk_out == '0);

  assert_reject_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && cfg_we && bad_sel) |=> cfg_nack);

  assert_no_stray_flag_R8: assert property (@(posedge clk) disable iff (rst)
    !(cfg_en && cfg_we) |=> !cfg_nack);

  assert_plain_table_R2: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && !act_dual && !act_oreg && act_sel == '0) |-> blk_out[0] == act_truth[din]);

  assert_lane_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && !act_dual) |-> blk_out[N_LANE-1] == 1'b0);

  assert_one_stage_R3: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && $past(!cfg_en) && $past(!rst) && act_dual && !act_oreg
     && act_sel[SEL_W-1:0] == SEL_W'(1) && act_sel[2*SEL_W-1:SEL_W] == '0)
    |-> blk_out[0] == $past(din[0]));

  assert_out_reg_R4: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && $past(!cfg_en) && $past(!rst) && !act_dual && act_oreg && act_sel == '0)
    |-> blk_out[0] == $past(act_truth[din]));
endmodule

bind rlb_block rlb_block_chk #(.LUT_K(LUT_K), .CHAIN_DEPTH(CHAIN_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .din(din), .cfg_en(cfg_en), .cfg_we(cfg_we),
  .cfg_delay(cfg_delay), .blk_out(blk_out), .cfg_nack(cfg_nack),
  .act_truth(act_truth), .act_sel(act_sel), .act_oreg(act_oreg), .act_dual(act_dual)
);

// File: tb/rlb_block_bench.sv
`timescale 1ns/1ps
module rlb_block_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  din;
  logic        cfg_en, cfg_we, cfg_oreg, cfg_dual;
  logic [15:0] cfg_truth;
  logic [11:0] cfg_delay;
  logic [1:0]  blk_out;
  logic        cfg_nack;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] rs = 32'h1234_5678;
  logic [3:0]  hist [0:63];

  logic [15:0] e_truth = '0;
  int          e_sel [4] = '{0, 0, 0, 0};
  logic        e_oreg = 1'b0;
  logic        e_dual = 1'b0;

  always #10 clk = ~clk;

  rlb_block u_rlb_block (
    .clk(clk), .rst(rst), .din(din), .cfg_en(cfg_en), .cfg_we(cfg_we),
    .cfg_truth(cfg_truth), .cfg_delay(cfg_delay), .cfg_oreg(cfg_oreg),
    .cfg_dual(cfg_dual), .blk_out(blk_out), .cfg_nack(cfg_nack)
  );

  task automatic step_rand();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
  endtask

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic hv(int t, int i);
    if (t < 0) return 1'b0;
    return hist[t][i];
  endfunction

  function automatic logic [1:0] raw_out(int t);
    logic [3:0] ix;
    if (e_dual) begin
      return {hv(t - e_sel[2] - e_sel[3], 2), hv(t - e_sel[0] - e_sel[1], 0)};
    end
    for (int i = 0; i < 4; i++) ix[i] = hv(t - e_sel[i], i);
    return {1'b0, e_truth[ix]};
  endfunction

  function automatic logic [1:0] exp_out(int t);
    if (!e_oreg) return raw_out(t);
    if (t == 0) return 2'b00;
    return raw_out(t - 1);
  endfunction

  // Called at a negedge; returns at the negedge with cfg_en low.
  task automatic do_cfg(input logic [15:0] tt, input int s0, input int s1, input int s2,
                        input int s3, input logic ob, input logic db);
    bit ok;
    ok = (s0 <= 4) && (s1 <= 4) && (s2 <= 4) && (s3 <= 4);
    cfg_en = 1'b1; cfg_we = 1'b1; cfg_truth = tt;
    cfg_delay = {3'(s3), 3'(s2), 3'(s1), 3'(s0)};
    cfg_oreg = ob; cfg_dual = db;
    step_rand(); din = rs[3:0];
    #1 chk("R9 idle", blk_out, 2'b00);
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
    chk("R7 flag", {1'b0, cfg_nack}, {1'b0, !ok});
    if (ok) begin
      e_truth = tt; e_sel = '{s0, s1, s2, s3}; e_oreg = ob; e_dual = db;
    end
    cfg_en = 1'b0;
  endtask

  task automatic run_cycles(input int n, input string req);
    for (int t = 0; t < n; t++) begin
      step_rand(); din = rs[3:0]; hist[t] = din;
      #1 chk(req, blk_out, exp_out(t));
      @(posedge clk); @(negedge clk);
    end
  endtask

  initial begin
    #(64'd3800000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; din = '0; cfg_en = 1'b0; cfg_we = 1'b0;
    cfg_truth = '0; cfg_delay = '0; cfg_oreg = 1'b0; cfg_dual = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 out", blk_out, 2'b00);
    chk("R1 nack", {1'b0, cfg_nack}, 2'b00);
    rst = 1'b0;
    run_cycles(8, "R1 default");

    // R2: index ordering, zero-delay table
    foreach (cfg_truth[b]) begin end
    for (int k = 0; k < 6; k++) begin
      logic [15:0] tt;
      tt = (k < 4) ? (16'h0001 << (k * 5)) : (k == 4 ? 16'h6996 : 16'hF0C3);
      do_cfg(tt, 0, 0, 0, 0, 1'b0, 1'b0);
      for (int v = 0; v < 16; v++) begin
        din = 4'(v);
        #1 chk("R2 index", blk_out, {1'b0, tt[v]});
        #1;
      end
    end

    // R3/R4/R6: table mode, every delay combination
    for (int ob = 0; ob < 2; ob++)
      for (int a = 0; a <= 4; a++)
        for (int b = 0; b <= 4; b++)
          for (int c = 0; c <= 4; c++)
            for (int d = 0; d <= 4; d++) begin
              step_rand();
              do_cfg(rs[15:0], a, b, c, d, 1'(ob), 1'b0);
              run_cycles(20, ob ? "R4 R6 table" : "R3 R6 table");
            end

    // R5: dual delay lines, every delay combination
    for (int ob = 0; ob < 2; ob++)
      for (int a = 0; a <= 4; a++)
        for (int b = 0; b <= 4; b++)
          for (int c = 0; c <= 4; c++)
            for (int d = 0; d <= 4; d++) begin
              step_rand();
              do_cfg(rs[15:0], a, b, c, d, 1'(ob), 1'b1);
              run_cycles(20, "R5 dual");
            end

    // R7: out-of-range select in each slot
    for (int slot = 0; slot < 4; slot++)
      for (int bv = 5; bv <= 7; bv++) begin
        int s [4];
        do_cfg(16'h3C5A, 1, 2, 3, 4, 1'b0, 1'b0);
        s = '{0, 0, 0, 0};
        s[slot] = bv;
        do_cfg(16'hFFFF, s[0], s[1], s[2], s[3], 1'b1, 1'b1);
        run_cycles(20, "R7 kept");
      end

    // R8: write strobe with enable low
    do_cfg(16'h9A17, 2, 0, 1, 3, 1'b0, 1'b0);
    cfg_we = 1'b1; cfg_truth = 16'h0000; cfg_delay = '0; cfg_oreg = 1'b1; cfg_dual = 1'b1;
    run_cycles(20, "R8 ignored");
    chk("R8 nack", {1'b0, cfg_nack}, 2'b00);
    cfg_we = 1'b0;

    // R9: idle window clears history
    do_cfg(16'hAAAA, 4, 4, 4, 4, 1'b1, 1'b1);
    run_cycles(12, "R5 pre-idle");
    cfg_en = 1'b1;
    for (int t = 0; t < 6; t++) begin
      step_rand(); din = rs[3:0];
      #1 chk("R9 hold", blk_out, 2'b00);
      @(posedge clk); @(negedge clk);
    end
    cfg_en = 1'b0;
    run_cycles(20, "R9 cleared");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule